// File: doc/BRIEF.md
# Serial Transceiver with Status Flags and Interrupts

This block is an asynchronous serial transmitter and receiver that a processor drives through four word-wide registers: one to hand over a character to send, one to collect a received character, a status word, and a control word. Characters are 8 data bits framed by a low start bit and a high stop bit, with an optional parity bit between them. The line runs off an external tick at sixteen times the bit rate, so each line bit lasts sixteen ticks. The data bits go out and come in least significant first or most significant first, as a status bit selects at run time.

The status word carries two interrupt enables and the bit-order select, which software can write, and five flags that software can only read: transmit holding empty, receive buffer full, and three sticky receive errors (framing, overrun, parity). The transmit interrupt follows the holding-empty flag. The receive interrupt is raised for a waiting character and also for any error flag. The error flags are sticky and go away only when the error-clear bit in the control word is written with 0. If the bit order is flipped while a character is still waiting to be sent, that character is dropped.

Register addresses: 0 transmit holding (write), 1 receive buffer (read; a read strobe empties it), 2 status, 3 control.

Top module: `sio_uart`

## Requirements
- R1: After reset the status word (address 2) reads 0x0800: only holding-empty (bit 11) is 1, the enables, order select and all other flags are 0; `txd` is high and both interrupts are low.
- R2: A write to address 0 clears holding-empty (bit 11) at the next edge; when the transmitter is idle the character moves into the shifter one cycle later and bit 11 returns to 1. `irq_tx` is high exactly when bit 8 (transmit interrupt enable) and bit 11 are both 1.
- R3: A sent frame is a 0 start bit, 8 data bits, a parity bit when control bit 0 is 1 (even parity, or odd when control bit 1 is also 1), and a 1 stop bit, each held for 16 ticks; status bit 10 at 0 sends data LSB first and at 1 sends MSB first.
- R4: The receiver detects a falling edge, confirms the start bit low on the 8th tick, samples every further bit 16 ticks apart, loads the character into address 1 (bits 7:0) and sets receive-full (bit 12); a read strobe on address 1 clears bit 12.
- R5: Reception follows the same bit order select (bit 10) as transmission and rebuilds the original byte in either order.
- R6: A stop bit sampled low sets the framing flag (bit 13).
- R7: A character that completes while bit 12 is still 1 sets the overrun flag (bit 14) and leaves the buffered character unchanged.
- R8: With parity enabled, a received parity bit that does not match the selected parity sets the parity flag (bit 15).
- R9: `irq_rx` is high when bit 9 (receive interrupt enable) is 1 and any of bits 12 to 15 is 1.
- R10: Bits 13 to 15 are cleared only by a write of 0 to control bit 10; writing 1 there, or reading the receive buffer, leaves them set.
- R11: Status bits 11 to 15 are read-only; a status write leaves them unchanged.
- R12: Changing bit 10 while a written character still waits (bit 11 at 0) discards it: bit 11 returns to 1 and the character is never sent.
- R13: A read strobe on address 1 in the same cycle a new character completes accepts the new character: bit 12 stays 1, the buffer holds the new byte and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect only at address 1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Two pairs of events can meet in one cycle. A processor read of the receive buffer can coincide with the stop-bit sample of the next character; the bench owns the tick, so it raises the read strobe on exactly the tick that samples the stop bit and then expects the new byte, receive-full still set and no overrun. A status write that flips the bit order can coincide with a pending character waiting behind a busy shifter; the bench stages that state, flips the order, and judges by holding-empty returning to 1, the running frame finishing with its original order, and the line staying idle afterwards.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
    localparam int BUS_W = 16;

    // register addresses
    localparam logic [1:0] ADR_TXD  = 2'd0;
    localparam logic [1:0] ADR_RXD  = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_CTRL = 2'd3;

    // status bit positions
    localparam int ST_TIE  = 8;
    localparam int ST_RIE  = 9;
    localparam int ST_MSB  = 10;
    localparam int ST_TDRE = 11;
    localparam int ST_RDRF = 12;
    localparam int ST_FRE  = 13;
    localparam int ST_ORE  = 14;
    localparam int ST_PE   = 15;

    // control bit positions
    localparam int CT_PEN  = 0;
    localparam int CT_PODD = 1;
    localparam int CT_ECLR = 10;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;
endpackage

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          msb_first,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          busy,
    output logic          txd
);
    localparam int CW = $clog2(OVS);
    localparam int FW = DW + 3;
    localparam int BW = $clog2(FW + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [BW-1:0] idx;
        logic [BW-1:0] last;
        logic [FW-1:0] sh;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [DW-1:0] rev;
    logic [DW-1:0] ordered;
    logic          par_bit;

    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign rev[i] = data[DW-1-i];
    end

    assign ordered = msb_first ? rev : data;
    assign par_bit = (^data) ^ par_odd;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (load) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.idx  = '0;
                d.sh   = {1'b1, (par_en ? par_bit : 1'b1), ordered, 1'b0};
                d.last = par_en ? BW'(DW + 2) : BW'(DW + 1);
            end
        end else if (tick) begin
            if (q.cnt == CW'(OVS - 1)) begin
                d.cnt = '0;
                d.sh  = {1'b1, q.sh[FW-1:1]};
                d.idx = q.idx + 1'b1;
                if (q.idx == q.last) d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign txd  = q.busy ? q.sh[0] : 1'b1;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !txd); // R3
    AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick) |=> $stable(txd)); // R3
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          msb_first,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DW);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          perr;
    } rx_regs_t;

    rx_regs_t q, d;
    logic     line;
    logic     bit_end;

    assign line    = q.s2;
    assign bit_end = tick && (q.cnt == CW'(OVS - 1));

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.prev = q.s2;
        if (tick && !bit_end) d.cnt = q.cnt + 1'b1;
        case (q.state)
            RX_IDLE: begin
                d.cnt = '0;
                if (q.prev && !line) d.state = RX_START;
            end
            RX_START: begin
                if (tick && q.cnt == CW'(HALF - 1)) begin
                    d.cnt = '0;
                    if (!line) begin
                        d.state = RX_DATA;
                        d.idx   = '0;
                        d.perr  = 1'b0;
                    end else begin
                        d.state = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    d.cnt = '0;
                    d.sh  = msb_first ? {q.sh[DW-2:0], line} : {line, q.sh[DW-1:1]};
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IW'(DW - 1)) d.state = par_en ? RX_PAR : RX_STOP;
                end
            end
            RX_PAR: begin
                if (bit_end) begin
                    d.cnt   = '0;
                    d.perr  = (^q.sh) ^ line ^ par_odd;
                    d.state = RX_STOP;
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    d.cnt   = '0;
                    d.state = RX_IDLE;
                end
            end
            default: d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done = (q.state == RX_STOP) && bit_end;
    assign data = q.sh;
    assign perr = q.perr;
    assign ferr = !line;

    AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_START && tick && q.cnt == CW'(HALF - 1) && line) |=> (q.state == RX_IDLE)); // R4
    AST_RX_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
endmodule

// File: rtl/sio_uart.sv
`timescale 1ns/1ps
module sio_uart
    import sio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    output logic             txd,
    output logic             irq_tx,
    output logic             irq_rx
);
    typedef struct packed {
        logic          tie;
        logic          rie;
        logic          msb;
        logic          tdre;
        logic          rdrf;
        logic          fre;
        logic          ore;
        logic          pe;
        logic          pen;
        logic          podd;
        logic [DW-1:0] hold;
        logic [DW-1:0] rbuf;
    } top_regs_t;

    top_regs_t q, d;
    logic wr_tx, wr_st, wr_ct, rd_rx;
    logic discard, tx_load, tx_busy;
    logic rx_done, rx_perr, rx_ferr;
    logic [DW-1:0] rx_data;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:ST_TDRE];

    assign wr_tx   = bus_wr && (bus_addr == ADR_TXD);
    assign wr_st   = bus_wr && (bus_addr == ADR_STAT);
    assign wr_ct   = bus_wr && (bus_addr == ADR_CTRL);
    assign rd_rx   = bus_rd && (bus_addr == ADR_RXD);
    assign discard = wr_st && (bus_wdata[ST_MSB] != q.msb) && !q.tdre;
    assign tx_load = !q.tdre && !tx_busy && !discard;

    sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .load      (tx_load),
        .data      (q.hold),
        .msb_first (q.msb),
        .par_en    (q.pen),
        .par_odd   (q.podd),
        .busy      (tx_busy),
        .txd       (txd)
    );

    sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rxd       (rxd),
        .msb_first (q.msb),
        .par_en    (q.pen),
        .par_odd   (q.podd),
        .done      (rx_done),
        .data      (rx_data),
        .perr      (rx_perr),
        .ferr      (rx_ferr)
    );

    always_comb begin
        d = q;
        if (tx_load || discard) d.tdre = 1'b1;
        if (wr_tx) begin
            d.hold = bus_wdata[DW-1:0];
            d.tdre = 1'b0;
        end
        if (wr_st) begin
            d.tie = bus_wdata[ST_TIE];
            d.rie = bus_wdata[ST_RIE];
            d.msb = bus_wdata[ST_MSB];
        end
        if (wr_ct) begin
            d.pen  = bus_wdata[CT_PEN];
            d.podd = bus_wdata[CT_PODD];
            if (!bus_wdata[CT_ECLR]) begin
                d.fre = 1'b0;
                d.ore = 1'b0;
                d.pe  = 1'b0;
            end
        end
        if (rd_rx) d.rdrf = 1'b0;
        if (rx_done) begin
            if (q.rdrf && !rd_rx) begin
                d.ore = 1'b1;
            end else begin
                d.rbuf = rx_data;
                d.rdrf = 1'b1;
                if (rx_ferr) d.fre = 1'b1;
                if (rx_perr) d.pe  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.tdre <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_TXD:  bus_rdata[DW-1:0] = q.hold;
            ADR_RXD:  bus_rdata[DW-1:0] = q.rbuf;
            ADR_STAT: bus_rdata[BUS_W-1:ST_TIE] =
                {q.pe, q.ore, q.fre, q.rdrf, q.tdre, q.msb, q.rie, q.tie};
            default: begin
                bus_rdata[CT_PEN]  = q.pen;
                bus_rdata[CT_PODD] = q.podd;
                bus_rdata[CT_ECLR] = 1'b1;
            end
        endcase
    end

    assign irq_tx = q.tie & q.tdre;
    assign irq_rx = q.rie & (q.rdrf | q.fre | q.ore | q.pe);

    AST_TDRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !q.tdre); // R2
    AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> (q.tdre && !$rose(tx_busy))); // R12
    AST_FRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fre && !(wr_ct && !bus_wdata[CT_ECLR])) |=> q.fre); // R10
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.rdrf && !rd_rx) |=> (q.ore && $stable(q.rbuf))); // R7
    AST_RD_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rd_rx) |=> (q.rdrf && !$rose(q.ore))); // R13
    AST_RX_IRQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rie && (q.fre || q.ore || q.pe)) |-> irq_rx); // R9
endmodule

// File: tb/sio_uart_bench.sv
`timescale 1ns/1ps
module sio_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq_tx;
    logic        irq_rx;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sio_uart u_sio_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rxd),
        .txd       (txd),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    // {data[14:7], msb, pen, podd, flip_parity, stop, exp_fre, exp_pe}
    localparam logic [14:0] RXV [7] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h96, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h0F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pop_rx();
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic one_tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] dat, input logic msb, input logic pen,
                            input logic podd, input logic flip, input logic stopv,
                            input logic collide);
        int nb;
        nb = pen ? 11 : 10;
        for (int b = 0; b < nb; b++) begin
            logic v;
            if (b == 0)                v = 1'b0;
            else if (b <= 8)           v = msb ? dat[8-b] : dat[b-1];
            else if (pen && b == 9)    v = (^dat) ^ podd ^ flip;
            else                       v = stopv;
            rxd = v;
            if (b == 0) repeat (4) @(negedge clk);
            for (int t = 1; t <= 16; t++) begin
                if (collide && b == nb - 1 && t == 8) begin
                    bus_addr = 2'd1; bus_rd = 1'b1;
                end
                baud_tick = 1'b1;
                @(negedge clk);
                baud_tick = 1'b0; bus_rd = 1'b0;
                @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic tx_expect(input logic [7:0] dat, input logic msb, input logic pen,
                             input logic podd, input string tag);
        int nb;
        nb = pen ? 11 : 10;
        for (int b = 0; b < nb; b++) begin
            logic v;
            if (b == 0)             v = 1'b0;
            else if (b <= 8)        v = msb ? dat[8-b] : dat[b-1];
            else if (pen && b == 9) v = (^dat) ^ podd;
            else                    v = 1'b1;
            for (int t = 1; t <= 16; t++) begin
                baud_tick = 1'b1;
                @(negedge clk);
                baud_tick = 1'b0;
                if (t == 8) chk($sformatf("%s bit %0d", tag, b), {15'h0, txd}, {15'h0, v});
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(2'd2, v);
        chk("R1 status", v, 16'h0800);
        chk("R1 lines", {13'h0, txd, irq_tx, irq_rx}, 16'h0004);

        // Receive vectors: R4 R5 R6 R8 R9 R10
        for (int i = 0; i < 7; i++) begin
            logic [7:0] dat;
            logic msb, pen, podd, flip, stopv, efre, epe;
            {dat, msb, pen, podd, flip, stopv, efre, epe} = RXV[i];
            bus_write(2'd3, {5'h0, 1'b1, 8'h0, podd, pen});
            bus_write(2'd2, {5'h0, msb, 1'b1, 1'b0, 8'h0});
            rx_frame(dat, msb, pen, podd, flip, stopv, 1'b0);
            peek(2'd2, v);
            chk($sformatf("R4 R6 R8 flags vec %0d", i), v & 16'hF000,
                {epe, 1'b0, efre, 1'b1, 12'h0});
            if (!efre) begin
                peek(2'd1, v);
                chk($sformatf("R4 R5 data vec %0d", i), v, {8'h0, dat});
            end
            chk($sformatf("R9 irq full vec %0d", i), {15'h0, irq_rx}, 16'h1);
            pop_rx();
            peek(2'd2, v);
            chk($sformatf("R4 R10 after read vec %0d", i), v & 16'hF000,
                {epe, 1'b0, efre, 1'b0, 12'h0});
            chk($sformatf("R9 irq err vec %0d", i), {15'h0, irq_rx}, {15'h0, epe | efre});
            bus_write(2'd3, {5'h0, 1'b1, 8'h0, podd, pen});
            peek(2'd2, v);
            chk($sformatf("R10 clear bit 1 vec %0d", i), v & 16'hE000, {epe, 1'b0, efre, 13'h0});
            bus_write(2'd3, {5'h0, 1'b0, 8'h0, podd, pen});
            peek(2'd2, v);
            chk($sformatf("R10 cleared vec %0d", i), v & 16'hF000, 16'h0);
            chk($sformatf("R9 irq idle vec %0d", i), {15'h0, irq_rx}, 16'h0);
        end

        // R11: read-only status bits
        bus_write(2'd2, 16'hF800);
        peek(2'd2, v);
        chk("R11 status write", v, 16'h0800);

        // R2 R3: LSB first, no parity, transmit interrupt
        bus_write(2'd3, 16'h0400);
        bus_write(2'd2, 16'h0100);
        chk("R2 irq empty", {15'h0, irq_tx}, 16'h1);
        bus_write(2'd0, 16'h00C3);
        peek(2'd2, v);
        chk("R2 empty cleared", v & 16'h0800, 16'h0);
        chk("R2 irq cleared", {15'h0, irq_tx}, 16'h0);
        @(negedge clk);
        peek(2'd2, v);
        chk("R2 empty set on load", v & 16'h0800, 16'h0800);
        chk("R2 irq on load", {15'h0, irq_tx}, 16'h1);
        tx_expect(8'hC3, 1'b0, 1'b0, 1'b0, "R3 lsb");

        // R3: MSB first, odd parity
        bus_write(2'd2, 16'h0500);
        bus_write(2'd3, 16'h0403);
        bus_write(2'd0, 16'h002D);
        @(negedge clk);
        tx_expect(8'h2D, 1'b1, 1'b1, 1'b1, "R3 msb odd");

        // R12: order flip discards pending character
        bus_write(2'd2, 16'h0100);
        bus_write(2'd0, 16'h0055);
        @(negedge clk);
        bus_write(2'd0, 16'h0077);
        peek(2'd2, v);
        chk("R12 pending", v & 16'h0800, 16'h0);
        bus_write(2'd2, 16'h0500);
        peek(2'd2, v);
        chk("R12 discard empty", v & 16'h0800, 16'h0800);
        tx_expect(8'h55, 1'b0, 1'b1, 1'b1, "R12 running frame");
        for (int t = 1; t <= 32; t++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            if (t == 8 || t == 24) chk("R12 line idle", {15'h0, txd}, 16'h1);
            @(negedge clk);
        end

        // R13 and R7: read collision, then overrun
        bus_write(2'd3, 16'h0400);
        bus_write(2'd2, 16'h0200);
        rx_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rx_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        peek(2'd2, v);
        chk("R13 full no overrun", v & 16'hF000, 16'h1000);
        peek(2'd1, v);
        chk("R13 new byte", v, 16'h0022);
        rx_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        peek(2'd2, v);
        chk("R7 overrun flag", v & 16'hF000, 16'h5000);
        peek(2'd1, v);
        chk("R7 old byte kept", v, 16'h0022);
        chk("R9 irq overrun", {15'h0, irq_rx}, 16'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule